// File: doc/BRIEF.md
# Debug Bus Comparator Trigger Unit

This block watches the bus of a CPU core and decides, one bus cycle at a time, whether a debug trigger should fire. Two 16-bit reference values, called comparator A and comparator B, are checked against the bus. Comparator A always checks the address. Comparator B checks either the address or an 8-bit data byte, depending on the trigger mode. A match can be narrowed down in two ways. The first is the bus direction, set separately for each comparator. The second is an "instruction executed" flag that an opcode-tracking stage outside this block supplies. The two range modes treat A and B as the lower and upper bounds of an address window.

A qualified match produces one registered, single-cycle pulse, one clock after the bus cycle. The pulse appears on one of four outputs, chosen by the action field: a breakpoint request to the CPU, a strobe to store the bus value into a trace buffer, a start-trace strobe, or a stop-trace strobe. Nothing fires while the unit is disarmed. Nothing fires while the background-debug port is using the bus. Control values come in as plain level inputs from a register file that sits elsewhere.

Top module: `dbg_trig_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all four trigger outputs are 0.
- R2: Mode code 0 fires when `bus_addr` equals `cmp_a`. Mode codes 5, 6 and 7 never fire. A cycle with `bus_valid` low never fires.
- R3: Mode code 1 fires when `bus_addr` equals `cmp_a` or equals `cmp_b`. Each comparator applies its own direction qualifier.
- R4: Mode code 2 fires when `bus_addr` equals `cmp_a` and the selected data byte equals `cmp_b[7:0]`. The selected byte is `bus_wdata` when `rwq_en_a`=1 and `rwq_rd_a`=0. In every other case it is `bus_rdata`.
- R5: Mode code 3 (inside range) fires when `cmp_a` ≤ `bus_addr` ≤ `cmp_b`. Both bounds are included.
- R6: Mode code 4 (outside range) fires when `bus_addr` < `cmp_a` or `bus_addr` > `cmp_b`. Comparator A's direction qualifier applies in both range modes.
- R7: When a comparator's qualifier enable (`rwq_en_a` or `rwq_en_b`) is 1, that comparator matches only if `bus_rd` equals its direction bit. The direction bit is 1 for read and 0 for write. When the enable is 0, `bus_rd` has no effect on that comparator.
- R8: When `exec_qual_en` is 1, a cycle with `bus_exec`=0 never fires.
- R9: A cycle with `bdm_busy`=1 never fires.
- R10: When `arm` is 0, no trigger output is asserted.
- R11: The action code selects which output pulses. Code 0 drives `brk_req`, 1 drives `trc_store`, 2 drives `trc_start` and 3 drives `trc_stop`. At most one output is high in any cycle.
- R12: A qualified bus cycle at clock edge n makes its output high from edge n+1 until edge n+2. The output is then low again unless the next cycle also qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables trigger generation |
| mode | input | 3 | Trigger mode code (0..4 defined) |
| action | input | 2 | Output selected by a qualified match |
| cmp_a | input | 16 | Comparator A reference / range low bound |
| cmp_b | input | 16 | Comparator B reference / range high bound / data byte in [7:0] |
| rwq_en_a | input | 1 | Direction qualification enable, comparator A |
| rwq_rd_a | input | 1 | Required direction for A (1 read, 0 write) |
| rwq_en_b | input | 1 | Direction qualification enable, comparator B |
| rwq_rd_b | input | 1 | Required direction for B (1 read, 0 write) |
| exec_qual_en | input | 1 | Require the executed flag for a match |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | 1 for read cycle, 0 for write cycle |
| bus_rdata | input | 8 | CPU read data bus |
| bus_wdata | input | 8 | CPU write data bus |
| bus_exec | input | 1 | Opcode at this address is executed |
| bdm_busy | input | 1 | Background-debug access in progress |
| brk_req | output | 1 | Breakpoint request pulse |
| trc_store | output | 1 | Store-bus-value pulse |
| trc_start | output | 1 | Begin change-of-flow trace pulse |
| trc_stop | output | 1 | End change-of-flow trace pulse |

## Verification
The assertions assume that control inputs and bus inputs change only between clock edges. They also assume a range mode is used only with `cmp_a` ≤ `cmp_b`. The inside-range bound check relies on that ordering. The stimulus always drives inputs on the falling edge and programs every range vector with a low bound below the high bound. Values for mode codes outside 0..4 are fed only in the table rows that expect no trigger.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 2;
  localparam int N_OUT  = 1 << ACT_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_A_EQ    = 3'd0,
    MODE_A_OR_B  = 3'd1,
    MODE_A_DATA  = 3'd2,
    MODE_INSIDE  = 3'd3,
    MODE_OUTSIDE = 3'd4
  } trig_mode_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_BRK    = 2'd0,
    ACT_STORE  = 2'd1,
    ACT_TSTART = 2'd2,
    ACT_TSTOP  = 2'd3
  } trig_act_e;
endpackage

// File: rtl/dbg_mag_cmp.sv
module dbg_mag_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] ref_val,
  output logic         eq,
  output logic         lt,
  output logic         gt
);
  always_comb begin
    eq = (val == ref_val);
    lt = (val <  ref_val);
    gt = (val >  ref_val);
  end
endmodule

// File: rtl/dbg_data_cmp.sv
module dbg_data_cmp #(
  parameter int W = 8
) (
  input  logic         use_wr,
  input  logic [W-1:0] rdata,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ref_val,
  output logic         eq
);
  logic [W-1:0] sel;

  always_comb begin
    sel = use_wr ? wdata : rdata;
    eq  = (sel == ref_val);
  end
endmodule

// File: rtl/dbg_trig_eval.sv
module dbg_trig_eval
  import dbg_trig_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        eq_v,
  input  logic [1:0]        lt_v,
  input  logic [1:0]        gt_v,
  input  logic              data_eq,
  input  logic              dir_ok_a,
  input  logic              dir_ok_b,
  output logic              cond
);
  logic a_hit, b_hit;

  always_comb begin
    a_hit = eq_v[0] && dir_ok_a;
    b_hit = eq_v[1] && dir_ok_b;
    case (mode)
      MODE_A_EQ:    cond = a_hit;
      MODE_A_OR_B:  cond = a_hit || b_hit;
      MODE_A_DATA:  cond = a_hit && data_eq && dir_ok_b;
      MODE_INSIDE:  cond = !lt_v[0] && !gt_v[1] && dir_ok_a;
      MODE_OUTSIDE: cond = (lt_v[0] || gt_v[1]) && dir_ok_a;
      default:      cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [MODE_W-1:0] mode,
  input  logic [ACT_W-1:0]  action,
  input  logic [AW-1:0]     cmp_a,
  input  logic [AW-1:0]     cmp_b,
  input  logic              rwq_en_a,
  input  logic              rwq_rd_a,
  input  logic              rwq_en_b,
  input  logic              rwq_rd_b,
  input  logic              exec_qual_en,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_exec,
  input  logic              bdm_busy,
  output logic              brk_req,
  output logic              trc_store,
  output logic              trc_start,
  output logic              trc_stop
);
  localparam int NCMP = 2;

  logic [NCMP-1:0][AW-1:0] refs;
  logic [NCMP-1:0]         eq_v, lt_v, gt_v;
  logic                    data_eq, use_wr;
  logic                    dir_ok_a, dir_ok_b;
  logic                    cond, gate_ok, hit;
  logic [N_OUT-1:0]        trig_d, trig_q;

  assign refs[0] = cmp_a;
  assign refs[1] = cmp_b;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    dbg_mag_cmp #(.W(AW)) u_cmp (
      .val     (bus_addr),
      .ref_val (refs[i]),
      .eq      (eq_v[i]),
      .lt      (lt_v[i]),
      .gt      (gt_v[i])
    );
  end

  // Write bus only when A is qualified on write cycles
  assign use_wr = rwq_en_a && !rwq_rd_a;

  dbg_data_cmp #(.W(DW)) u_data (
    .use_wr  (use_wr),
    .rdata   (bus_rdata),
    .wdata   (bus_wdata),
    .ref_val (cmp_b[DW-1:0]),
    .eq      (data_eq)
  );

  assign dir_ok_a = !rwq_en_a || (bus_rd == rwq_rd_a);
  assign dir_ok_b = !rwq_en_b || (bus_rd == rwq_rd_b);

  dbg_trig_eval u_eval (
    .mode     (mode),
    .eq_v     (eq_v),
    .lt_v     (lt_v),
    .gt_v     (gt_v),
    .data_eq  (data_eq),
    .dir_ok_a (dir_ok_a),
    .dir_ok_b (dir_ok_b),
    .cond     (cond)
  );

  always_comb begin
    gate_ok = arm && bus_valid && !bdm_busy && (!exec_qual_en || bus_exec);
    hit     = gate_ok && cond;
    trig_d  = '0;
    if (hit) trig_d[action] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_d;
  end

  assign brk_req   = trig_q[ACT_BRK];
  assign trc_store = trig_q[ACT_STORE];
  assign trc_start = trig_q[ACT_TSTART];
  assign trc_stop  = trig_q[ACT_TSTOP];

  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !(brk_req || trc_store || trc_start || trc_stop)); // R10
  AST_BDM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bdm_busy |=> !(brk_req || trc_store || trc_start || trc_stop)); // R9
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !(brk_req || trc_store || trc_start || trc_stop)); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_req, trc_store, trc_start, trc_stop})); // R11
  AST_EXEC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_qual_en && !bus_exec) |=> !(brk_req || trc_store || trc_start || trc_stop)); // R8
  AST_INSIDE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_INSIDE) |-> (bus_addr >= cmp_a && bus_addr <= cmp_b)); // R5
  AST_OUTSIDE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_OUTSIDE) |-> (bus_addr < cmp_a || bus_addr > cmp_b)); // R6
endmodule

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mode;
    logic [1:0]  act;
    logic [15:0] a;
    logic [15:0] b;
    logic        rwea;
    logic        rwda;
    logic        rweb;
    logic        rwdb;
    logic        exen;
    logic [15:0] addr;
    logic        rd;
    logic [7:0]  rdat;
    logic [7:0]  wdat;
    logic        ex;
    logic [3:0]  exp;   // {stop,start,store,brk}
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R2 equality on A, miss, unused mode
    '{4'd2, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0001},
    '{4'd2, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1001, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    '{4'd2, 3'd5, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    // R3 A or B
    '{4'd3, 3'd1, 2'd1, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1010, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0010},
    '{4'd3, 3'd1, 2'd1, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0010},
    '{4'd3, 3'd1, 2'd1, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1005, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    // R4 address plus data, bus selection
    '{4'd4, 3'd2, 2'd0, 16'h1000, 16'h00A5, 1'b1,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b0, 8'h00, 8'hA5, 1'b0, 4'b0001},
    '{4'd4, 3'd2, 2'd0, 16'h1000, 16'h00A5, 1'b1,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b0, 8'hA5, 8'h00, 1'b0, 4'b0000},
    '{4'd4, 3'd2, 2'd0, 16'h1000, 16'h00A5, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'hA5, 8'h00, 1'b0, 4'b0001},
    // R5 inside range, inclusive bounds
    '{4'd5, 3'd3, 2'd2, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0100},
    '{4'd5, 3'd3, 2'd2, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1010, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0100},
    '{4'd5, 3'd3, 2'd2, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0FFF, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    '{4'd5, 3'd3, 2'd2, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1011, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    // R6 outside range
    '{4'd6, 3'd4, 2'd3, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0FFF, 1'b1, 8'h00, 8'h00, 1'b0, 4'b1000},
    '{4'd6, 3'd4, 2'd3, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1011, 1'b1, 8'h00, 8'h00, 1'b0, 4'b1000},
    '{4'd6, 3'd4, 2'd3, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    // R7 direction qualification
    '{4'd7, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b1,1'b1,1'b0,1'b0,1'b0, 16'h1000, 1'b0, 8'h00, 8'h00, 1'b0, 4'b0000},
    '{4'd7, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b1,1'b1,1'b0,1'b0,1'b0, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0001},
    '{4'd7, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b1,1'b0,1'b0,1'b0, 16'h1000, 1'b0, 8'h00, 8'h00, 1'b0, 4'b0001},
    '{4'd7, 3'd1, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b1,1'b0,1'b0, 16'h1010, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    '{4'd7, 3'd4, 2'd0, 16'h1000, 16'h1010, 1'b1,1'b0,1'b0,1'b0,1'b0, 16'h2000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    // R8 executed qualifier
    '{4'd8, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b1, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0000},
    '{4'd8, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b1, 16'h1000, 1'b1, 8'h00, 8'h00, 1'b1, 4'b0001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic arm;
  logic [2:0] mode;
  logic [1:0] action;
  logic [15:0] cmp_a, cmp_b, bus_addr;
  logic rwq_en_a, rwq_rd_a, rwq_en_b, rwq_rd_b, exec_qual_en;
  logic bus_valid, bus_rd, bus_exec, bdm_busy;
  logic [7:0] bus_rdata, bus_wdata;
  logic brk_req, trc_store, trc_start, trc_stop;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dbg_trig_unit dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .action(action),
    .cmp_a(cmp_a), .cmp_b(cmp_b),
    .rwq_en_a(rwq_en_a), .rwq_rd_a(rwq_rd_a), .rwq_en_b(rwq_en_b), .rwq_rd_b(rwq_rd_b),
    .exec_qual_en(exec_qual_en), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .bus_exec(bus_exec), .bdm_busy(bdm_busy),
    .brk_req(brk_req), .trc_store(trc_store), .trc_start(trc_start), .trc_stop(trc_stop)
  );

  function automatic logic [3:0] outs();
    return {trc_stop, trc_start, trc_store, brk_req};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_checks++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic load(input vec_t v);
    mode = v.mode; action = v.act; cmp_a = v.a; cmp_b = v.b;
    rwq_en_a = v.rwea; rwq_rd_a = v.rwda; rwq_en_b = v.rweb; rwq_rd_b = v.rwdb;
    exec_qual_en = v.exen; bus_addr = v.addr; bus_rd = v.rd;
    bus_rdata = v.rdat; bus_wdata = v.wdat; bus_exec = v.ex;
    bus_valid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  localparam vec_t HIT0 = '{4'd2, 3'd0, 2'd0, 16'h1000, 16'h1010, 1'b0,1'b0,1'b0,1'b0,1'b0,
                            16'h1000, 1'b1, 8'h00, 8'h00, 1'b0, 4'b0001};

  initial begin
    rst_n = 1'b0; arm = 1'b0; bdm_busy = 1'b0;
    load(HIT0); bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 4'b0000);
    arm = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load(VECS[i]);
      @(negedge clk);
      bus_valid = 1'b0;
      check($sformatf("R%0d table row %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R11 each action code selects its own output
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      load(HIT0); action = 2'(k);
      @(negedge clk);
      bus_valid = 1'b0;
      check($sformatf("R11 action %0d", k), 4'(1 << k));
    end

    // R12 pulse lasts one cycle, back-to-back hits hold it
    @(negedge clk); load(HIT0);
    @(negedge clk); check("R12 first hit", 4'b0001);
    @(negedge clk); bus_valid = 1'b0; check("R12 back-to-back", 4'b0001);
    @(negedge clk); check("R12 drop", 4'b0000);

    // R10 disarmed
    @(negedge clk); load(HIT0); arm = 1'b0;
    @(negedge clk); check("R10 disarmed", 4'b0000);
    arm = 1'b1; bus_valid = 1'b0;

    // R9 background-debug access
    @(negedge clk); load(HIT0); bdm_busy = 1'b1;
    @(negedge clk); check("R9 bdm busy", 4'b0000);
    bdm_busy = 1'b0; bus_valid = 1'b0;

    // R2 invalid bus cycle
    @(negedge clk); load(HIT0); bus_valid = 1'b0;
    @(negedge clk); check("R2 bus idle", 4'b0000);

    // R1 asynchronous reset clears a pending pulse
    @(negedge clk); load(HIT0);
    @(negedge clk); bus_valid = 1'b0; check("R1 pulse before reset", 4'b0001);
    #1 rst_n = 1'b0;
    #0.5 check("R1 async clear", 4'b0000);
    idle();
    rst_n = 1'b1;
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule